// File: doc/BRIEF.md
# Shadow Protection and Attribute Register Replica

This block keeps a local copy of two tables of region descriptors next to the logic that checks physical addresses. One table carries access permissions. The other carries memory attributes and has its own CSR addresses. The copy does not take part in the CSR read path. It follows the architectural registers by watching the CSR unit's write port. That port is a valid strobe, a 12-bit CSR number and 64 bits of data, and every write seen on it has already been accepted. The register contents therefore always equal those held in the CSR unit.

For every entry the block outputs the 8-bit configuration byte, the stored address register and a precomputed match mask. The mask has its low i bits set, where i is log2 of the region size in bytes. The smallest region is 4 KB. The mask is written on the same clock edge as the configuration or address it depends on, so a downstream checker needs only an AND and a compare per entry. The attribute table reuses two configuration bits, otherwise reserved, as an "atomics allowed" flag and a "cacheable" flag. It comes out of reset holding a small platform memory map.

Top module: `shadow_pmp_copy`

## Requirements
- R1: After reset, every protection entry has configuration 0x00 (mode off), address 0 and mask 0xFFF. Attribute entry 0 holds configuration 0x0B and address 0x2000_0000. Attribute entry 1 holds configuration 0x6F and address 0x2_0000_0000. All other attribute entries are zero, and every attribute mask is 0xFFF.
- R2: State changes only on a cycle with the write valid strobe high and a decoded CSR number. Writes to an odd configuration number, to a configuration number past the last entry, or to a number outside both tables leave every output unchanged.
- R3: The configuration CSR at base+2k holds entries 8k to 8k+7, with entry 8k+j in data bits [8j+7:8j]. Protection configuration base is 0x3A0 and address base is 0x3B0. Attribute configuration base is 0x7C0 and address base is 0x7D0. The address CSR at base+i writes data bits [PA_W-3:0] (physical address bits [PA_W-1:2]) into entry i.
- R4: The fields of a configuration byte are: bit 0 read, bit 1 write, bit 2 execute, bits [4:3] mode (0 off, 1 top-of-range, 2 four-byte, 3 naturally aligned power of two), bit 5 atomics allowed, bit 6 cacheable, bit 7 lock. Protection entries always store bits 6:5 as zero. Attribute entries keep them as written.
- R5: In mode 3, an address register with x trailing ones gives a mask with i = max(12, x+3) low ones, capped at PA_W bits. For example, 0xBFFF gives 0x1FFFF, 0x3FF gives 0x1FFF, and an address ending in 0 gives 0xFFF.
- R6: In every mode other than 3 the mask is 0xFFF, so the low 12 bits of every mask are always set.
- R7: A write to an entry's configuration or address updates that entry's mask on the same clock edge as the register. Outputs change at the first rising edge at which the write is presented.
- R8: Writes to the configuration byte or the address register of an entry whose lock bit is set are ignored. Other bytes carried by the same configuration write still update.
- R9: When entry i is locked in top-of-range mode, writes to the address register of entry i-1 are ignored. A lock in any other mode does not protect entry i-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_wr_valid | input | 1 | An accepted CSR write is present this cycle |
| csr_wr_addr | input | 12 | CSR number of the write |
| csr_wr_data | input | 64 | Write data |
| pmp_cfg_o | output | N*8 | Protection configuration bytes, entry i at [8i+7:8i] |
| pmp_addr_o | output | N*(PA_W-2) | Protection address registers |
| pmp_mask_o | output | N*PA_W | Protection match masks |
| pma_cfg_o | output | N*8 | Attribute configuration bytes |
| pma_addr_o | output | N*(PA_W-2) | Attribute address registers |
| pma_mask_o | output | N*PA_W | Attribute match masks |

## Verification
The bench exercises the trailing-ones corner cases of the mask:
- A trailing zero, which must not yield a zero-size region.
- Runs short enough that the 4 KB floor applies.
- A 14-bit run, which yields the 128 KB example.
- An all-ones address, whose size must saturate at the full physical width rather than wrap.

A design that refreshed the mask only on address writes would leave a stale mask after a mode change, and the mode-toggle sequence exposes that.

The lock checks cover three cases. They hit a locked entry's own registers, and a design that failed here would let privileged code rewrite a frozen region. They hit the entry below a locked top-of-range entry, where a missing guard would let the range base move. They also hit the entry below a lock in power-of-two mode, where an over-eager guard would wrongly block the write.

Odd, out-of-range and non-valid writes are sent to show that a loose decoder does not corrupt neighbouring entries.

// File: rtl/shadow_pmp_pkg.sv
// Shared constants and helper functions for the shadow register replica.
// Assumes configuration bytes of 8 bits and a 4 KB minimum region.
package shadow_pmp_pkg;

    localparam int CFG_W      = 8;
    localparam int GRAIN_LOG2 = 12;
    localparam int LOCK_BIT   = 7;
    localparam int CACHE_BIT  = 6;
    localparam int ATOM_BIT   = 5;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_TOR   = 2'd1,
        MODE_NA4   = 2'd2,
        MODE_NAPOT = 2'd3
    } match_mode_e;

    // log2 of the matched region in bytes, floored at the grain and capped at pa_w
    function automatic int region_log2(input logic [7:0] cfg, input logic [63:0] addr,
                                       input int aw, input int pa_w);
        int  ones;
        int  lg;
        bit  run;
        ones = 0;
        run  = 1'b1;
        for (int b = 0; b < 64; b++) begin
            if (b < aw) begin
                if (run && addr[b]) ones++;
                else run = 1'b0;
            end
        end
        lg = ones + 3;
        if (cfg[4:3] != MODE_NAPOT) lg = GRAIN_LOG2;
        if (lg < GRAIN_LOG2) lg = GRAIN_LOG2;
        if (lg > pa_w) lg = pa_w;
        return lg;
    endfunction

    // Reset configuration byte of the attribute table: low I/O window, then memory
    function automatic logic [7:0] pma_reset_cfg(input int idx);
        case (idx)
            0:       return 8'h0B;   // read, write, top-of-range
            1:       return 8'h6F;   // rwx, atomics, cacheable, top-of-range
            default: return 8'h00;
        endcase
    endfunction

    // Reset address register of the attribute table (physical address >> 2)
    function automatic logic [63:0] pma_reset_addr(input int idx);
        case (idx)
            0:       return 64'h0000_0000_2000_0000;
            1:       return 64'h0000_0002_0000_0000;
            default: return 64'h0;
        endcase
    endfunction

endpackage

// File: rtl/shadow_csr_decode.sv
// Decodes one snooped CSR write into per-entry write enables for one table.
// Assumes 64-bit configuration CSRs at even offsets, eight entries each.
module shadow_csr_decode #(
    parameter int          N          = 16,
    parameter int          PA_W       = 36,
    parameter logic [11:0] CFG_BASE   = 12'h3A0,
    parameter logic [11:0] ADDR_BASE  = 12'h3B0,
    parameter bit          KEEP_ATTR  = 1'b0
) (
    input  logic                 wr_valid,
    input  logic [11:0]          wr_addr,
    input  logic [63:0]          wr_data,
    output logic [N-1:0]         cfg_we,
    output logic [N*8-1:0]       cfg_wdata,
    output logic [N-1:0]         addr_we,
    output logic [PA_W-3:0]      addr_wdata
);
    import shadow_pmp_pkg::*;

    localparam int          AW        = PA_W - 2;
    localparam logic [7:0]  BYTE_KEEP = KEEP_ATTR ? 8'hFF : 8'h9F;

    logic [11:0] cfg_off;
    logic [11:0] addr_off;

    // Offsets of the write relative to each register group
    always_comb begin
        cfg_off  = wr_addr - CFG_BASE;
        addr_off = wr_addr - ADDR_BASE;
    end

    assign addr_wdata = wr_data[AW-1:0];

    for (genvar i = 0; i < N; i++) begin : g_ent
        // Per-entry select and byte extraction
        always_comb begin
            cfg_we[i]           = wr_valid && (cfg_off == 12'(2 * (i / 8)));
            addr_we[i]          = wr_valid && (addr_off == 12'(i));
            cfg_wdata[i*8 +: 8] = wr_data[(i % 8) * 8 +: 8] & BYTE_KEEP;
        end
    end

endmodule

// File: rtl/shadow_entry.sv
// One replicated entry: configuration byte, address register and match mask.
// Assumes write enables are already gated by the lock rules.
module shadow_entry #(
    parameter int PA_W = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       rst_cfg,
    input  logic [PA_W-3:0]  rst_addr,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    input  logic             addr_we,
    input  logic [PA_W-3:0]  addr_wdata,
    output logic [7:0]       cfg_q,
    output logic [PA_W-3:0]  addr_q,
    output logic [PA_W-1:0]  mask_q
);
    import shadow_pmp_pkg::*;

    localparam int AW = PA_W - 2;

    logic [7:0]      cfg_d;
    logic [AW-1:0]   addr_d;
    logic [PA_W-1:0] mask_d;
    logic [PA_W-1:0] mask_rst;
    int              lg_d;
    int              lg_rst;

    // Next-state values and the mask derived from them
    always_comb begin
        cfg_d  = cfg_we  ? cfg_wdata  : cfg_q;
        addr_d = addr_we ? addr_wdata : addr_q;
        lg_d   = region_log2(cfg_d, {{(64-AW){1'b0}}, addr_d}, AW, PA_W);
        lg_rst = region_log2(rst_cfg, {{(64-AW){1'b0}}, rst_addr}, AW, PA_W);
        for (int b = 0; b < PA_W; b++) begin
            mask_d[b]   = (b < lg_d);
            mask_rst[b] = (b < lg_rst);
        end
    end

    // Register the entry and its mask together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= rst_cfg;
            addr_q <= rst_addr;
            mask_q <= mask_rst;
        end else if (cfg_we || addr_we) begin
            cfg_q  <= cfg_d;
            addr_q <= addr_d;
            mask_q <= mask_d;
        end
    end

endmodule

// File: rtl/shadow_pmp_table.sv
// One table of N replicated entries with lock gating and reset defaults.
// IS_ATTR selects the attribute variant (reserved bits kept, map reset).
module shadow_pmp_table #(
    parameter int          N         = 16,
    parameter int          PA_W      = 36,
    parameter logic [11:0] CFG_BASE  = 12'h3A0,
    parameter logic [11:0] ADDR_BASE = 12'h3B0,
    parameter bit          IS_ATTR   = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_valid,
    input  logic [11:0]           wr_addr,
    input  logic [63:0]           wr_data,
    output logic [N*8-1:0]        cfg_o,
    output logic [N*(PA_W-2)-1:0] addr_o,
    output logic [N*PA_W-1:0]     mask_o
);
    import shadow_pmp_pkg::*;

    localparam int AW = PA_W - 2;

    logic [N-1:0]     dec_cfg_we;
    logic [N-1:0]     dec_addr_we;
    logic [N*8-1:0]   dec_cfg_wdata;
    logic [AW-1:0]    dec_addr_wdata;
    logic [N-1:0]     locked;
    logic [N-1:0]     tor_locked;

    shadow_csr_decode #(
        .N(N), .PA_W(PA_W), .CFG_BASE(CFG_BASE), .ADDR_BASE(ADDR_BASE), .KEEP_ATTR(IS_ATTR)
    ) dec_i (
        .wr_valid   (wr_valid),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cfg_we     (dec_cfg_we),
        .cfg_wdata  (dec_cfg_wdata),
        .addr_we    (dec_addr_we),
        .addr_wdata (dec_addr_wdata)
    );

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic [7:0]    rst_cfg;
        logic [AW-1:0] rst_addr;
        logic          guard_next;
        logic          cfg_we_g;
        logic          addr_we_g;

        if (IS_ATTR) begin : g_attr_rst
            localparam logic [63:0] RST_A = pma_reset_addr(i);
            assign rst_cfg  = pma_reset_cfg(i);
            assign rst_addr = RST_A[AW-1:0];
        end else begin : g_prot_rst
            assign rst_cfg  = 8'h00;
            assign rst_addr = '0;
        end

        // Lock state of this entry
        always_comb begin
            locked[i]     = cfg_o[i*8 + LOCK_BIT];
            tor_locked[i] = locked[i] && (cfg_o[i*8+3 +: 2] == MODE_TOR);
        end

        if (i + 1 < N) begin : g_guard
            assign guard_next = tor_locked[i+1];
        end else begin : g_noguard
            assign guard_next = 1'b0;
        end

        // Suppress writes blocked by this entry's lock or the next entry's TOR lock
        always_comb begin
            cfg_we_g  = dec_cfg_we[i]  && !locked[i];
            addr_we_g = dec_addr_we[i] && !locked[i] && !guard_next;
        end

        shadow_entry #(.PA_W(PA_W)) ent_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .rst_cfg    (rst_cfg),
            .rst_addr   (rst_addr),
            .cfg_we     (cfg_we_g),
            .cfg_wdata  (dec_cfg_wdata[i*8 +: 8]),
            .addr_we    (addr_we_g),
            .addr_wdata (dec_addr_wdata),
            .cfg_q      (cfg_o[i*8 +: 8]),
            .addr_q     (addr_o[i*AW +: AW]),
            .mask_q     (mask_o[i*PA_W +: PA_W])
        );
    end

endmodule

// File: rtl/shadow_pmp_copy.sv
// Top: replica of the protection table and the attribute table, kept coherent
// by snooping accepted CSR writes. Assumes writes arrive already validated.
module shadow_pmp_copy #(
    parameter int          N              = 16,
    parameter int          PA_W           = 36,
    parameter logic [11:0] PMP_CFG_BASE   = 12'h3A0,
    parameter logic [11:0] PMP_ADDR_BASE  = 12'h3B0,
    parameter logic [11:0] PMA_CFG_BASE   = 12'h7C0,
    parameter logic [11:0] PMA_ADDR_BASE  = 12'h7D0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  csr_wr_valid,
    input  logic [11:0]           csr_wr_addr,
    input  logic [63:0]           csr_wr_data,
    output logic [N*8-1:0]        pmp_cfg_o,
    output logic [N*(PA_W-2)-1:0] pmp_addr_o,
    output logic [N*PA_W-1:0]     pmp_mask_o,
    output logic [N*8-1:0]        pma_cfg_o,
    output logic [N*(PA_W-2)-1:0] pma_addr_o,
    output logic [N*PA_W-1:0]     pma_mask_o
);

    shadow_pmp_table #(
        .N(N), .PA_W(PA_W), .CFG_BASE(PMP_CFG_BASE), .ADDR_BASE(PMP_ADDR_BASE), .IS_ATTR(1'b0)
    ) prot_i (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(csr_wr_valid), .wr_addr(csr_wr_addr), .wr_data(csr_wr_data),
        .cfg_o(pmp_cfg_o), .addr_o(pmp_addr_o), .mask_o(pmp_mask_o)
    );

    shadow_pmp_table #(
        .N(N), .PA_W(PA_W), .CFG_BASE(PMA_CFG_BASE), .ADDR_BASE(PMA_ADDR_BASE), .IS_ATTR(1'b1)
    ) attr_i (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(csr_wr_valid), .wr_addr(csr_wr_addr), .wr_data(csr_wr_data),
        .cfg_o(pma_cfg_o), .addr_o(pma_addr_o), .mask_o(pma_mask_o)
    );

endmodule

// File: rtl/shadow_pmp_copy_checker.sv
// Property checker for shadow_pmp_copy, attached by bind below.
module shadow_pmp_copy_checker #(
    parameter int N    = 16,
    parameter int PA_W = 36
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  csr_wr_valid,
    input logic [N*8-1:0]        pmp_cfg_o,
    input logic [N*(PA_W-2)-1:0] pmp_addr_o,
    input logic [N*PA_W-1:0]     pmp_mask_o,
    input logic [N*8-1:0]        pma_cfg_o,
    input logic [N*(PA_W-2)-1:0] pma_addr_o,
    input logic [N*PA_W-1:0]     pma_mask_o
);
    localparam int AW = PA_W - 2;

    // Without a write nothing moves
    p_hold_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_wr_valid |=> ($stable(pmp_cfg_o) && $stable(pmp_addr_o) && $stable(pmp_mask_o)
                         && $stable(pma_cfg_o) && $stable(pma_addr_o) && $stable(pma_mask_o)));

    for (genvar i = 0; i < N; i++) begin : g_chk
        // Protection entries never carry attribute bits
        p_prot_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
            pmp_cfg_o[i*8+5 +: 2] == 2'b00);

        // Masks are contiguous low ones
        p_mask_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ((pmp_mask_o[i*PA_W +: PA_W] & (pmp_mask_o[i*PA_W +: PA_W] + 1'b1)) == '0)
            && ((pma_mask_o[i*PA_W +: PA_W] & (pma_mask_o[i*PA_W +: PA_W] + 1'b1)) == '0));

        // 4 KB floor
        p_grain_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (pmp_mask_o[i*PA_W +: 12] == 12'hFFF) && (pma_mask_o[i*PA_W +: 12] == 12'hFFF));

        // Locked entries are frozen
        p_lock_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
            pmp_cfg_o[i*8+7] |=> ($stable(pmp_cfg_o[i*8 +: 8]) && $stable(pmp_addr_o[i*AW +: AW])));
        p_lock_frozen_attr_r8: assert property (@(posedge clk) disable iff (!rst_n)
            pma_cfg_o[i*8+7] |=> ($stable(pma_cfg_o[i*8 +: 8]) && $stable(pma_addr_o[i*AW +: AW])));

        if (i + 1 < N) begin : g_tor
            // TOR lock on the next entry freezes this address
            p_tor_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (pmp_cfg_o[(i+1)*8+7] && pmp_cfg_o[(i+1)*8+3 +: 2] == 2'd1)
                |=> $stable(pmp_addr_o[i*AW +: AW]));
        end
    end

endmodule

bind shadow_pmp_copy shadow_pmp_copy_checker #(.N(N), .PA_W(PA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .csr_wr_valid(csr_wr_valid),
    .pmp_cfg_o(pmp_cfg_o), .pmp_addr_o(pmp_addr_o), .pmp_mask_o(pmp_mask_o),
    .pma_cfg_o(pma_cfg_o), .pma_addr_o(pma_addr_o), .pma_mask_o(pma_mask_o)
);

// File: tb/shadow_pmp_copy_tb_top.sv
`timescale 1ns/1ps
module shadow_pmp_copy_tb_top;
    localparam int N    = 16;
    localparam int PA_W = 36;
    localparam int AW   = PA_W - 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                csr_wr_valid = 1'b0;
    logic [11:0]         csr_wr_addr = '0;
    logic [63:0]         csr_wr_data = '0;
    logic [N*8-1:0]      pmp_cfg_o;
    logic [N*AW-1:0]     pmp_addr_o;
    logic [N*PA_W-1:0]   pmp_mask_o;
    logic [N*8-1:0]      pma_cfg_o;
    logic [N*AW-1:0]     pma_addr_o;
    logic [N*PA_W-1:0]   pma_mask_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    shadow_pmp_copy #(.N(N), .PA_W(PA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .csr_wr_valid(csr_wr_valid),
        .csr_wr_addr(csr_wr_addr), .csr_wr_data(csr_wr_data),
        .pmp_cfg_o(pmp_cfg_o), .pmp_addr_o(pmp_addr_o), .pmp_mask_o(pmp_mask_o),
        .pma_cfg_o(pma_cfg_o), .pma_addr_o(pma_addr_o), .pma_mask_o(pma_mask_o)
    );

    function automatic logic [63:0] p_cfg(input int i);  return 64'(pmp_cfg_o[i*8 +: 8]);        endfunction
    function automatic logic [63:0] p_adr(input int i);  return 64'(pmp_addr_o[i*AW +: AW]);      endfunction
    function automatic logic [63:0] p_msk(input int i);  return 64'(pmp_mask_o[i*PA_W +: PA_W]);  endfunction
    function automatic logic [63:0] a_cfg(input int i);  return 64'(pma_cfg_o[i*8 +: 8]);        endfunction
    function automatic logic [63:0] a_adr(input int i);  return 64'(pma_addr_o[i*AW +: AW]);      endfunction
    function automatic logic [63:0] a_msk(input int i);  return 64'(pma_mask_o[i*PA_W +: PA_W]);  endfunction

    // Expected mask from R5/R6
    function automatic logic [63:0] exp_mask(input logic napot, input logic [63:0] adr);
        int ones = 0;
        int lg;
        logic [63:0] m = '0;
        for (int b = 0; b < AW; b++) begin
            if (adr[b] && ones == b) ones++;
        end
        lg = napot ? ones + 3 : 12;
        if (lg < 12) lg = 12;
        if (lg > PA_W) lg = PA_W;
        for (int b = 0; b < lg; b++) m[b] = 1'b1;
        return m;
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic csr_write(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        csr_wr_valid = 1'b1; csr_wr_addr = a; csr_wr_data = d;
        @(negedge clk);
        csr_wr_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_values();
        for (int i = 0; i < N; i++) begin
            chk("R1", $sformatf("pmp cfg %0d", i), p_cfg(i), 64'h0);
            chk("R1", $sformatf("pmp addr %0d", i), p_adr(i), 64'h0);
            chk("R1", $sformatf("pmp mask %0d", i), p_msk(i), 64'hFFF);
            chk("R1", $sformatf("pma cfg %0d", i), a_cfg(i), i == 0 ? 64'h0B : (i == 1 ? 64'h6F : 64'h0));
            chk("R1", $sformatf("pma addr %0d", i), a_adr(i),
                i == 0 ? 64'h2000_0000 : (i == 1 ? 64'h2_0000_0000 : 64'h0));
            chk("R1", $sformatf("pma mask %0d", i), a_msk(i), 64'hFFF);
        end
    endtask

    task automatic t_layout();
        csr_write(12'h3A2, 64'h0807_0605_0403_0201);
        for (int i = 0; i < 8; i++) begin
            chk("R3", $sformatf("upper cfg byte %0d", i), p_cfg(8 + i), 64'(i + 1));
            chk("R3", $sformatf("lower cfg untouched %0d", i), p_cfg(i), 64'h0);
        end
        csr_write(12'h3B9, 64'hABCD_0001_2345_6788);
        chk("R3", "addr9 truncated to PA_W-2 bits", p_adr(9), 64'h1_2345_6788);
        chk("R6", "addr9 mode off mask", p_msk(9), 64'hFFF);
        chk("R3", "addr8 untouched", p_adr(8), 64'h0);
    endtask

    task automatic t_napot();
        csr_write(12'h3B3, 64'hBFFF);
        chk("R6", "addr3 before mode set", p_msk(3), 64'hFFF);
        csr_write(12'h3B4, 64'hF000);
        csr_write(12'h3B2, 64'h3FF);
        csr_write(12'h3B1, 64'h3_FFFF_FFFF);
        csr_write(12'h3A0, 64'h0000_0018_1F18_1800);
        chk("R5", "0xBFFF gives 128KB", p_msk(3), 64'h1_FFFF);
        chk("R5", "bench model agrees", p_msk(3), exp_mask(1'b1, 64'hBFFF));
        chk("R5", "trailing zero gives 4KB", p_msk(4), 64'hFFF);
        chk("R5", "10 ones gives 8KB", p_msk(2), 64'h1FFF);
        chk("R5", "all ones saturates", p_msk(1), exp_mask(1'b1, 64'h3_FFFF_FFFF));
        chk("R5", "all ones is full width", p_msk(1), 64'hF_FFFF_FFFF);
    endtask

    task automatic t_refresh();
        csr_write(12'h3A0, 64'h0000_0018_0F18_1800);
        chk("R7", "mode to TOR drops mask", p_msk(3), 64'hFFF);
        csr_write(12'h3A0, 64'h0000_0018_1F18_1800);
        chk("R7", "mode back to NAPOT", p_msk(3), 64'h1_FFFF);
        csr_write(12'h3B3, 64'h7);
        chk("R7", "address rewrite same edge", p_msk(3), 64'hFFF);
        csr_write(12'h3B3, 64'h7FFFF);
        chk("R7", "19 ones", p_msk(3), exp_mask(1'b1, 64'h7FFFF));
    endtask

    task automatic t_attr_bits();
        csr_write(12'h3A0, 64'h67);
        chk("R4", "protection drops bits 6:5", p_cfg(0), 64'h07);
        csr_write(12'h7C0, 64'h7B_6F0B);
        chk("R4", "attribute keeps bits 6:5", a_cfg(2), 64'h7B);
        chk("R4", "attribute entry0 kept", a_cfg(0), 64'h0B);
        csr_write(12'h7D2, 64'h3FFF);
        chk("R5", "attribute NAPOT mask", a_msk(2), 64'h1_FFFF);
        chk("R3", "attribute write leaves protection addr", p_adr(2), 64'h3FF);
    endtask

    task automatic t_ignored();
        logic [63:0] c0;
        logic [63:0] a6;
        c0 = p_cfg(0); a6 = p_adr(6);
        @(negedge clk);
        csr_wr_addr = 12'h3B6; csr_wr_data = 64'h1234;
        @(negedge clk);
        chk("R2", "no valid, addr6 held", p_adr(6), a6);
        csr_write(12'h3A1, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R2", "odd cfg number ignored", p_cfg(0), c0);
        csr_write(12'h3A4, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R2", "cfg number past end ignored", p_cfg(15), 64'h08);
        csr_write(12'h3C0, 64'h55);
        chk("R2", "addr number past end ignored", p_adr(0), 64'h0);
        chk("R2", "unrelated number leaves attribute", a_adr(0), 64'h2000_0000);
    endtask

    task automatic t_lock();
        do_reset();
        csr_write(12'h3B4, 64'h100);
        csr_write(12'h3B5, 64'h200);
        csr_write(12'h3A0, 64'h0000_8901_0000_0000);
        csr_write(12'h3B5, 64'h999);
        chk("R8", "locked addr5 held", p_adr(5), 64'h200);
        csr_write(12'h3B4, 64'h777);
        chk("R9", "addr4 below TOR lock held", p_adr(4), 64'h100);
        csr_write(12'h3B6, 64'h55);
        chk("R8", "unlocked addr6 written", p_adr(6), 64'h55);
        csr_write(12'h3A0, 64'h9800_0003_0000_0000);
        chk("R8", "locked cfg5 held", p_cfg(5), 64'h89);
        chk("R8", "same write updates cfg4", p_cfg(4), 64'h03);
        chk("R8", "same write updates cfg7", p_cfg(7), 64'h98);
        csr_write(12'h3B6, 64'h66);
        chk("R9", "NAPOT lock does not guard addr6", p_adr(6), 64'h66);
        csr_write(12'h3B7, 64'h77);
        chk("R8", "locked addr7 held", p_adr(7), 64'h0);
    endtask

    initial begin
        #(5.0 * 100000);
        n_checks++; n_fail++;
        $display("FAIL all: watchdog expired, actual hang expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        do_reset();
        t_reset_values();
        t_layout();
        t_napot();
        t_refresh();
        t_attr_bits();
        t_ignored();
        t_lock();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule